// File: doc/BRIEF.md
# Four-Channel PWM DAC Generator

This block converts one 8-bit code per channel into a pulse-width modulated logic level. After an external low-pass filter, each output works as a coarse analogue level. All four channels share one step counter. A prescaler on the system clock advances that counter, so every channel sees the same frame boundaries. Within a frame, an output is high for the first N steps and low for the remaining steps, where N is the channel's code.

Software writes codes through a simple strobe interface: a write enable, a channel index and a data byte. The stored code can be read back at once. A new code is held back and only starts to drive its output at the next frame boundary, so no frame ever contains a shortened or split pulse.

Two global controls select the frame rate and the frame length:
- The frame rate is either the base rate or double that rate. The double rate halves the prescaler division.
- The frame length is either 256 steps or 253 steps. In the 253-step frame, the three top codes hold the output high all the time. In the 256-step frame, the output always has at least one low step, even for the top code.

Top module: `pwm_dac_bank`

## Requirements
- R1: The four channels are independent: a write with `wr_en`=1 changes only the channel selected by `wr_idx` (0..3), and the other channels keep their codes and duty cycles.
- R2: `rd_data` shows the stored code of channel `rd_idx` on the clock after the write that set it.
- R3: With `frame253`=0 a frame is 256 steps long; with `frame253`=1 it is 253 steps long. Each step lasts `STEP_DIV` clocks (default 2) when `fast_rate`=0, so a frame is 512 or 506 clocks long.
- R4: With `frame253`=1, the codes FDh, FEh and FFh keep the output high for every clock of the frame.
- R5: With `frame253`=0, code FFh gives exactly one low step per frame (high for 255 of 256 steps).
- R6: Code 00h keeps the output low in both frame lengths.
- R7: After reset every channel holds code 80h, which gives 128 high steps per frame.
- R8: For a code N, the output is high for the first min(N, frame length) steps of each frame and low for the rest.
- R9: A written code takes effect only at the next frame boundary. The frame that is in progress during the write completes with the old code.
- R10: With `fast_rate`=1, each step lasts `STEP_DIV`/2 clocks, so the frame period is halved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_rate | input | 1 | 1 selects the double frame rate |
| frame253 | input | 1 | 1 selects the 253-step frame, 0 selects the 256-step frame |
| wr_en | input | 1 | Write strobe for one channel code |
| wr_idx | input | 2 | Channel index for the write |
| wr_data | input | 8 | Code to write |
| rd_idx | input | 2 | Channel index for read-back |
| rd_data | output | 8 | Stored code of the selected channel |
| pwm_out | output | 4 | PWM output, one bit per channel |

## Verification
Duty cycle is measured as the number of high clocks over a window of exactly one frame. Because the window is one full frame, the result does not depend on where in the frame the window starts. The codes used are:
- the reset code 80h and the codes 01h, 40h and C0h, which separate an off-by-one comparison from a correct one;
- 00h, FCh, FDh, FEh and FFh, which separate the saturating 253-step frame from the 256-step frame that always has a low step.

The frame period is measured from rising edge to rising edge for both frame lengths and both rates. A write made just after a rising edge shows whether the frame in progress keeps its old pulse width.

// File: rtl/pwm_dac_pkg.sv
// Shared code type and frame constants for the PWM DAC bank.
package pwm_dac_pkg;
    typedef logic [7:0] code_t;
    localparam code_t CODE_MID   = 8'h80;  // reset code, mid-scale
    localparam code_t LAST_FULL  = 8'd255; // last step index, 256-step frame
    localparam code_t LAST_SHORT = 8'd252; // last step index, 253-step frame
endpackage

// File: rtl/pwm_step_timer.sv
// Prescaler and shared step counter.
// Assumes STEP_DIV is even and at least 2, so that the fast rate divides by STEP_DIV/2.
// frame_wrap pulses on the clock edge that returns the step counter to 0.
module pwm_step_timer
    import pwm_dac_pkg::*;
#(
    parameter int STEP_DIV = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fast_rate,
    input  logic  frame253,
    output code_t step,
    output logic  frame_wrap
);
    localparam int PW = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
    localparam logic [PW-1:0] SLOW_M1 = PW'(STEP_DIV - 1);
    localparam logic [PW-1:0] FAST_M1 = PW'(STEP_DIV / 2 - 1);

    logic [PW-1:0] presc_q;
    logic          tick;
    code_t         last;

    assign tick       = presc_q >= (fast_rate ? FAST_M1 : SLOW_M1);
    assign last       = frame253 ? LAST_SHORT : LAST_FULL;
    assign frame_wrap = tick && (step >= last);

    // Prescaler: counts clocks within one step.
    always_ff @(posedge clk) begin
        if (!rst_n)    presc_q <= '0;
        else if (tick) presc_q <= '0;
        else           presc_q <= presc_q + 1'b1;
    end

    // Step counter: advances once per tick and wraps at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          step <= '0;
        else if (frame_wrap) step <= '0;
        else if (tick)       step <= step + 1'b1;
    end
endmodule

// File: rtl/pwm_chan_reg.sv
// Holds one channel's code: a pending copy that writes update at once,
// and an active copy that is loaded from it only at a frame boundary.
module pwm_chan_reg
    import pwm_dac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  code_t wdata,
    input  logic  load,
    output code_t pending,
    output code_t active
);
    // Pending code: takes the written value on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  pending <= CODE_MID;
        else if (wr) pending <= wdata;
    end

    // Active code: copies the pending code at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= CODE_MID;
        else if (load) active <= pending;
    end
endmodule

// File: rtl/pwm_chan_cmp.sv
// Per-channel comparator: the output is high while the step index is below the code.
// Codes at or above the frame length therefore keep the output high for the whole frame.
module pwm_chan_cmp
    import pwm_dac_pkg::*;
(
    input  code_t step,
    input  code_t active,
    output logic  level
);
    // Compare the step index with the active code.
    always_comb level = step < active;
endmodule

// File: rtl/pwm_dac_bank.sv
// Top level: NCH PWM channels that share one step timer.
// Assumes one clock domain and a synchronous active-low reset.
module pwm_dac_bank
    import pwm_dac_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int STEP_DIV = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fast_rate,
    input  logic                   frame253,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [$clog2(NCH)-1:0] rd_idx,
    output logic [7:0]             rd_data,
    output logic [NCH-1:0]         pwm_out
);
    code_t step;
    logic  frame_wrap;
    code_t pend_q   [NCH];
    code_t active_q [NCH];

    pwm_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_rate  (fast_rate),
        .frame253   (frame253),
        .step       (step),
        .frame_wrap (frame_wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr_idx == i[$clog2(NCH)-1:0]);

        pwm_chan_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (sel),
            .wdata   (wr_data),
            .load    (frame_wrap),
            .pending (pend_q[i]),
            .active  (active_q[i])
        );

        pwm_chan_cmp u_cmp (
            .step   (step),
            .active (active_q[i]),
            .level  (pwm_out[i])
        );
    end

    // Read-back mux over the pending codes.
    always_comb rd_data = pend_q[rd_idx];
endmodule

// File: rtl/pwm_dac_bank_chk.sv
// Assertion checker for pwm_dac_bank, attached through bind.
module pwm_dac_bank_chk
    import pwm_dac_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame253,
    input code_t          step,
    input code_t          active [NCH],
    input logic [NCH-1:0] pwm_out
);
    // R3: the step index only advances by one or returns to 0.
    p_step_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step) |-> (step == 8'd0 || step == $past(step) + 8'd1));

    // R5: the last step of a 256-step frame is low on every channel.
    p_last_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame253 && step == LAST_FULL) |-> (pwm_out == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9: the active code changes only where a new frame begins.
        p_load_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(active[i]) |-> (step == 8'd0));

        // R6: code 00h never drives the output high.
        p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (active[i] == 8'h00) |-> !pwm_out[i]);

        // R4: in the short frame the top codes hold the output high.
        p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (frame253 && step <= LAST_SHORT && active[i] >= 8'd253) |-> pwm_out[i]);
    end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame253 (frame253),
    .step     (step),
    .active   (active_q),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_dac_bank_test.sv
module pwm_dac_bank_test;
    localparam int NCH = 4;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_rate = 1'b0;
    logic       frame253 = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic [3:0] pwm_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [7:0] codes [NCH];

    always #10 clk = ~clk;

    pwm_dac_bank #(.NCH(NCH), .STEP_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate), .frame253(frame253),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int frame_len();
        return frame253 ? 253 : 256;
    endfunction

    function automatic int step_clks();
        return fast_rate ? DIV / 2 : DIV;
    endfunction

    function automatic int exp_high(int code);
        return ((code < frame_len()) ? code : frame_len()) * step_clks();
    endfunction

    task automatic write_code(int ch, int code);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(ch); wr_data = 8'(code);
        @(negedge clk);
        wr_en = 1'b0;
        codes[ch] = 8'(code);
    endtask

    task automatic settle();
        repeat (2 * 256 * DIV + 8) @(negedge clk);
    endtask

    task automatic high_count(int ch, output int hi);
        hi = 0;
        repeat (frame_len() * step_clks()) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(int ch);
        logic prev;
        @(negedge clk); prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic check_all_duty(string req);
        int hi;
        for (int c = 0; c < NCH; c++) begin
            high_count(c, hi);
            chk(req, hi, exp_high(codes[c]));
        end
    endtask

    // R7: reset codes and mid-scale duty.
    task automatic t_reset();
        for (int c = 0; c < NCH; c++) begin
            codes[c] = 8'h80;
            rd_idx = 2'(c); @(negedge clk);
            chk("R7 reset code", rd_data, 8'h80);
        end
        check_all_duty("R7 reset duty");
    endtask

    // R2/R1: read-back and per-channel isolation.
    task automatic t_readback();
        for (int c = 0; c < NCH; c++) write_code(c, 8'h11 * (c + 3));
        for (int c = 0; c < NCH; c++) begin
            rd_idx = 2'(c); @(negedge clk);
            chk("R2 readback", rd_data, 8'h11 * (c + 3));
        end
        write_code(1, 8'h5A);
        rd_idx = 2'd1; @(negedge clk);
        chk("R2 readback after one write", rd_data, 8'h5A);
        rd_idx = 2'd0; @(negedge clk);
        chk("R1 other channel untouched", rd_data, 8'h33);
        settle();
        check_all_duty("R1 independent duty");
    endtask

    // R8: duty for several codes in the 256-step frame.
    task automatic t_duty();
        int vals [3] = '{8'h01, 8'h40, 8'hC0};
        int hi;
        foreach (vals[k]) begin
            write_code(2, vals[k]);
            settle();
            high_count(2, hi);
            chk("R8 duty", hi, exp_high(vals[k]));
        end
        check_all_duty("R1 others after ch2 writes");
    endtask

    // R6: code 00h low in both frames.
    task automatic t_zero();
        int hi;
        for (int m = 0; m < 2; m++) begin
            frame253 = m[0];
            write_code(3, 8'h00);
            settle();
            high_count(3, hi);
            chk("R6 zero code low", hi, 0);
        end
        frame253 = 1'b0;
    endtask

    // R5: FFh in 256-step frame keeps one low step.
    task automatic t_full256();
        int hi;
        frame253 = 1'b0;
        write_code(0, 8'hFF);
        settle();
        high_count(0, hi);
        chk("R5 FFh one low step", hi, 255 * DIV);
    endtask

    // R4/R8: saturation in the 253-step frame.
    task automatic t_short();
        int vals [4] = '{8'hFD, 8'hFE, 8'hFF, 8'hFC};
        int hi;
        frame253 = 1'b1;
        foreach (vals[k]) begin
            write_code(1, vals[k]);
            settle();
            high_count(1, hi);
            chk((vals[k] == 8'hFC) ? "R8 FCh short frame" : "R4 saturated high",
                hi, (vals[k] == 8'hFC) ? 252 * DIV : 253 * DIV);
        end
        frame253 = 1'b0;
    endtask

    // R3/R10: frame periods for both lengths and rates.
    task automatic t_period();
        int cyc;
        write_code(2, 8'h80);
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 2; m++) begin
                fast_rate = r[0]; frame253 = m[0];
                settle();
                wait_rise(2);
                cyc = 0;
                wait_rise(2);
                cyc = 0;
                begin
                    logic prev = 1'b1;
                    forever begin
                        @(negedge clk); cyc++;
                        if (!prev && pwm_out[2]) break;
                        prev = pwm_out[2];
                    end
                end
                chk(r ? "R10 fast period" : "R3 frame period", cyc, frame_len() * step_clks());
            end
            check_all_duty(r ? "R10 fast duty" : "R3 duty");
        end
        fast_rate = 1'b0; frame253 = 1'b0;
    endtask

    // R9: a write mid-frame leaves the current pulse intact.
    task automatic t_boundary();
        int len;
        write_code(0, 8'h80);
        settle();
        wait_rise(0);
        wr_en = 1'b1; wr_idx = 2'd0; wr_data = 8'h20;
        len = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm_out[0]) begin len++; @(negedge clk); end
        chk("R9 current frame keeps old code", len, 128 * DIV);
        wait_rise(0);
        len = 1;
        @(negedge clk);
        while (pwm_out[0]) begin len++; @(negedge clk); end
        chk("R9 next frame uses new code", len, 32 * DIV);
        codes[0] = 8'h20;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_duty();
        t_zero();
        t_full256();
        t_short();
        t_period();
        t_boundary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule